// File: doc/BRIEF.md
# Eight-Way Set-Associative Write-Back Data Cache

This block is a byte-addressed data cache that sits between a processor's load/store port and a slower line-oriented memory. It holds 128 slots of 32 bytes, grouped as 16 sets of 8 ways. On each request, the eight tags of the selected set are compared at the same time. A hit is answered in the same cycle: a read returns its byte, and a write updates the stored byte and marks the line modified.

On a miss the cache raises a stall and picks a victim way. An empty way is used first. If the set is full, the oldest line in the set is chosen. A modified victim is first sent to the lower memory as a whole line. The missing line is then fetched as one 256-bit transfer. The cycle after the fetch is acknowledged, the held request completes as a hit.

The requester must keep its request, address, write flag and write data stable while the stall is high.

Top module: `sa_cache`

## Requirements
- R1: After reset every slot is invalid. With no request pending, cpuHit, cpuStall and memReq are all 0. The first access to any address is a miss.
- R2: The address splits as follows: bits 8..5 select the set, bits 31..9 are the tag, and bits 4..0 select the byte. A read hit returns, in the same cycle, the byte at that offset with cpuHit=1 and cpuStall=0.
- R3: A write hit replaces the addressed byte and marks the line modified. It causes no lower-memory transfer.
- R4: A miss raises cpuStall in the cycle of the request. It issues one fetch (memWe=0) with memAddr set to the request address with bits 4..0 cleared. The request then hits in the cycle after the fetch acknowledge, and sees the fetched data.
- R5: Empty ways of a set are filled before any line is evicted. Eight distinct lines of one set all stay resident.
- R6: In a full set, the victim is the line that was filled earliest among the resident lines of that set (first in, first out).
- R7: A modified victim is written back before the fetch. The write-back has memWe=1, memAddr equal to the victim's tag and set with bits 4..0 zero, and memWline holding its current contents, including earlier byte writes.
- R8: An unmodified victim is dropped without a write-back.
- R9: cpuStall stays 1, and cpuHit stays 0, from the missing request until the fetch is acknowledged.
- R10: While memReq is 1 and memAck is 0, memReq, memWe, memAddr and memWline stay unchanged.
- R11: Activity in one set never removes or alters lines in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cpuReq | input | 1 | Access request, held while stalled |
| cpuWe | input | 1 | 1 = byte write, 0 = byte read |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 8 | Byte to write |
| cpuRdata | output | 8 | Byte read on a hit |
| cpuHit | output | 1 | Access completes this cycle |
| cpuStall | output | 1 | Access is waiting on a miss |
| memReq | output | 1 | Line transfer request |
| memWe | output | 1 | 1 = write-back, 0 = fetch |
| memAddr | output | 32 | Line-aligned transfer address |
| memWline | output | 256 | Line sent on write-back, byte 0 in bits 7..0 |
| memRline | input | 256 | Fetched line, valid with memAck |
| memAck | input | 1 | One-cycle transfer acknowledge |

## Verification
A corrupted valid bit or tag shows up on the first access to that set. It appears either as an unexpected fetch or as a hit where the reference model predicts a miss, so the error is visible in the request cycle.

A lost modified flag shows up only when that line is evicted: the write-back is missing, and a later fetch of the line returns stale bytes. A wrong replacement pointer likewise surfaces only on the next eviction in that set, as a write-back or later miss of the wrong line.

The bench therefore compares every transfer, hit and read byte against a queue-based model over long mixed sequences that evict repeatedly.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FETCH = 2'd2
  } cacheState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureVictim;
    logic fillLine;
    logic writeByte;
  } cacheStrobe_t;

endpackage

// File: rtl/sa_cache_dp.sv
module sa_cache_dp
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cacheStrobe_t              strb,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [7:0]                cpuWdata,
  input  logic [LINE_BYTES*8-1:0]   memRline,
  output logic                      hit,
  output logic                      victimDirtyNow,
  output logic [7:0]                cpuRdata,
  output logic [ADDR_W-1:0]         wbAddr,
  output logic [LINE_BYTES*8-1:0]   wbLine
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int SLOTS  = SETS * WAYS;
  localparam int SLOT_W = SET_W + WAY_W;

  logic [SLOTS-1:0]  validQ;
  logic [SLOTS-1:0]  dirtyQ;
  logic [TAG_W-1:0]  tagQ  [SLOTS];
  logic [LINE_W-1:0] dataQ [SLOTS];
  logic [WAY_W-1:0]  ptrQ  [SETS];

  logic [WAY_W-1:0]  victimQ;
  logic              victimValidQ;

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagIn;
  logic [OFF_W-1:0]  offIdx;
  assign setIdx = cpuAddr[OFF_W +: SET_W];
  assign tagIn  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign offIdx = cpuAddr[OFF_W-1:0];

  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] freeVec;

  // Parallel tag compare across the ways of the indexed set
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SLOT_W-1:0] wSlot;
    assign wSlot      = {setIdx, WAY_W'(w)};
    assign hitVec[w]  = validQ[wSlot] && (tagQ[wSlot] == tagIn);
    assign freeVec[w] = !validQ[wSlot];
  end

  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] freeWay;
  logic             anyFree;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  // Lowest-numbered empty way wins
  always_comb begin
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (freeVec[w]) freeWay = WAY_W'(w);
    end
  end

  assign anyFree = |freeVec;
  assign hit     = |hitVec;

  logic [SLOT_W-1:0] hitSlot;
  logic [SLOT_W-1:0] ptrSlot;
  logic [SLOT_W-1:0] vicSlot;
  assign hitSlot = {setIdx, hitWay};
  assign ptrSlot = {setIdx, ptrQ[setIdx]};
  assign vicSlot = {setIdx, victimQ};

  assign victimDirtyNow = !anyFree && dirtyQ[ptrSlot];
  assign cpuRdata       = dataQ[hitSlot][{offIdx, 3'b000} +: 8];
  assign wbAddr         = {tagQ[vicSlot], setIdx, {OFF_W{1'b0}}};
  assign wbLine         = dataQ[vicSlot];

  // Victim is latched at the miss; the requester keeps the address stable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimQ      <= '0;
      victimValidQ <= 1'b0;
    end else if (strb.captureVictim) begin
      victimQ      <= anyFree ? freeWay : ptrQ[setIdx];
      victimValidQ <= !anyFree;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      for (int s = 0; s < SETS; s++) ptrQ[s] <= '0;
    end else begin
      if (strb.fillLine) begin
        validQ[vicSlot] <= 1'b1;
        dirtyQ[vicSlot] <= 1'b0;
        if (victimValidQ) ptrQ[setIdx] <= ptrQ[setIdx] + 1'b1;
      end else if (strb.writeByte) begin
        dirtyQ[hitSlot] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      tagQ[vicSlot]  <= tagIn;
      dataQ[vicSlot] <= memRline;
    end else if (strb.writeByte) begin
      dataQ[hitSlot][{offIdx, 3'b000} +: 8] <= cpuWdata;
    end
  end

  // R2
  single_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> hit);

endmodule

// File: rtl/sa_cache_ctl.sv
module sa_cache_ctl
  import sa_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic         hit,
  input  logic         victimDirtyNow,
  input  logic         memAck,
  output cacheStrobe_t strb,
  output logic         cpuHit,
  output logic         cpuStall,
  output logic         memReq,
  output logic         memWe
);
  cacheState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    cpuHit   = 1'b0;
    cpuStall = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hit) begin
            cpuHit         = 1'b1;
            strb.writeByte = cpuWe;
          end else begin
            cpuStall           = 1'b1;
            strb.captureVictim = 1'b1;
            stateD             = victimDirtyNow ? ST_WBACK : ST_FETCH;
          end
        end
      end
      ST_WBACK: begin
        cpuStall = 1'b1;
        memReq   = 1'b1;
        memWe    = 1'b1;
        if (memAck) stateD = ST_FETCH;
      end
      ST_FETCH: begin
        cpuStall = 1'b1;
        memReq   = 1'b1;
        if (memAck) begin
          strb.fillLine = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R9
  hit_stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuHit && cpuStall));

  // R9
  mem_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuStall);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R7
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuWdata,
  output logic [7:0]              cpuRdata,
  output logic                    cpuHit,
  output logic                    cpuStall,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0] memWline,
  input  logic [LINE_BYTES*8-1:0] memRline,
  input  logic                    memAck
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  cacheStrobe_t      strb;
  logic              hit;
  logic              victimDirtyNow;
  logic [ADDR_W-1:0] wbAddr;

  sa_cache_dp #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRline(memRline), .hit(hit),
    .victimDirtyNow(victimDirtyNow), .cpuRdata(cpuRdata),
    .wbAddr(wbAddr), .wbLine(memWline)
  );

  sa_cache_ctl ctl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .victimDirtyNow(victimDirtyNow), .memAck(memAck), .strb(strb),
    .cpuHit(cpuHit), .cpuStall(cpuStall), .memReq(memReq), .memWe(memWe)
  );

  assign memAddr = memWe ? wbAddr
                         : {cpuAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWline)));

endmodule

// File: tb/sa_cache_tb_top.sv
module sa_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0]  cpuAddr = '0;
  logic [7:0]   cpuWdata = '0;
  logic [7:0]   cpuRdata;
  logic         cpuHit, cpuStall, memReq, memWe;
  logic [31:0]  memAddr;
  logic [255:0] memWline;
  logic [255:0] memRline = '0;
  logic         memAck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa_cache dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuHit(cpuHit), .cpuStall(cpuStall), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWline(memWline), .memRline(memRline),
    .memAck(memAck)
  );

  int total = 0, fails = 0, cycles = 0, holdErr = 0, txCount = 0;
  bit finished = 0;

  typedef struct { bit we; logic [31:0] a; logic [255:0] d; } tx_t;
  tx_t txQ[$];

  // Behavioural lower memory and reference cache state
  logic [255:0] memArr [logic [31:0]];
  logic [255:0] modelLine [logic [31:0]];
  bit           dirtyM [logic [31:0]];
  logic [31:0]  setQ [16][$];

  function automatic logic [255:0] memRead(logic [31:0] la);
    logic [255:0] l;
    if (memArr.exists(la)) return memArr[la];
    for (int j = 0; j < 32; j++)
      l[j*8 +: 8] = 8'(la[15:5] * 13 + j * 7 + la[23:16] + la[31:24]);
    return l;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WD_LIMIT);
      summary();
      $finish;
    end
  end

  // Lower memory responder: latency 1..3 cycles, one-cycle acknowledge
  int           lat = 0;
  bit           holdSeen = 0;
  logic [31:0]  heldAddr;
  logic         heldWe;
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; lat = 0; holdSeen = 0;
    end else if (memAck) begin
      memAck <= 1'b0; lat = 0; holdSeen = 0;
    end else if (memReq) begin
      if (holdSeen && (memAddr !== heldAddr || memWe !== heldWe)) holdErr++;
      heldAddr = memAddr; heldWe = memWe; holdSeen = 1;
      if (lat >= (txCount % 3)) begin
        memAck <= 1'b1;
        txQ.push_back('{we: memWe, a: memAddr, d: memWline});
        txCount++;
        if (memWe) memArr[memAddr] = memWline;
        else       memRline <= memRead(memAddr);
      end else begin
        lat++;
      end
    end
  end

  function automatic bit resident(logic [31:0] la, int s);
    foreach (setQ[s][i]) if (setQ[s][i] == la) return 1;
    return 0;
  endfunction

  // One access, checked against the model; starts and ends at a falling edge
  task automatic access(input bit we, input logic [31:0] addr,
                        input logic [7:0] wd, input string rq);
    logic [31:0] la;
    int          s;
    bit          mHit, evict, vDirty, stallOk;
    logic [31:0] vict;
    logic [255:0] vData;
    int          cyc;
    logic [7:0]  expB;
    la = {addr[31:5], 5'b0};
    s  = int'(addr[8:5]);
    mHit = resident(la, s);
    evict = 0; vDirty = 0; vict = '0; vData = '0;
    if (!mHit && setQ[s].size() == 8) begin
      evict = 1;
      vict  = setQ[s][0];
      vDirty = dirtyM.exists(vict) && dirtyM[vict];
      vData = modelLine[vict];
    end
    txQ.delete();
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    #1;
    chk(cpuHit == mHit && cpuStall == !mHit,
        {rq, " first-cycle hit/stall (R2/R4)"},
        {cpuHit, cpuStall}, {mHit, !mHit});
    if (!mHit) begin
      cyc = 0; stallOk = 1;
      while (!cpuHit && cyc < 60) begin
        @(negedge clk); #1; cyc++;
        if (!cpuHit && !cpuStall) stallOk = 0;
      end
      chk(stallOk && cpuHit, {rq, " R9 stall held until refill completes"},
          {stallOk, cpuHit}, 2'b11);
      if (evict) begin
        void'(setQ[s].pop_front());
        modelLine.delete(vict);
        dirtyM.delete(vict);
      end
      if (vDirty) begin
        chk(txQ.size() == 2, {rq, " R7 write-back plus fetch count"}, txQ.size(), 2);
        if (txQ.size() == 2) begin
          chk(txQ[0].we && txQ[0].a == vict, {rq, " R7 write-back address"},
              {txQ[0].we, txQ[0].a}, {1'b1, vict});
          chk(txQ[0].d == vData, {rq, " R7 write-back line data"}, txQ[0].d, vData);
          chk(!txQ[1].we && txQ[1].a == la, {rq, " R4 fetch address"},
              {txQ[1].we, txQ[1].a}, {1'b0, la});
        end
      end else begin
        chk(txQ.size() == 1, {rq, " R8/R4 single fetch, no write-back"}, txQ.size(), 1);
        if (txQ.size() == 1)
          chk(!txQ[0].we && txQ[0].a == la, {rq, " R4 fetch address"},
              {txQ[0].we, txQ[0].a}, {1'b0, la});
      end
      modelLine[la] = memRead(la);
      dirtyM[la] = 0;
      setQ[s].push_back(la);
    end
    expB = modelLine[la][addr[4:0]*8 +: 8];
    if (!we) begin
      chk(cpuRdata == expB, {rq, " R2 read byte"}, cpuRdata, expB);
    end else begin
      modelLine[la][addr[4:0]*8 +: 8] = wd;
      dirtyM[la] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    if (mHit)
      chk(txQ.size() == 0, {rq, " R3 hit makes no memory transfer"}, txQ.size(), 0);
  endtask

  function automatic logic [31:0] mkAddr(int tag, int set, int off);
    return {23'(tag), 4'(set), 5'(off)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!cpuHit && !cpuStall && !memReq, "R1 idle outputs after reset",
        {cpuHit, cpuStall, memReq}, 3'b000);
    @(negedge clk);

    access(0, 32'h0000_1234, 8'h00, "R1 first access misses");
    access(0, 32'h0000_123F, 8'h00, "R2 other offset hit");
    access(1, 32'h0000_1221, 8'hA5, "R3 write hit");
    access(0, 32'h0000_1221, 8'h00, "R3 read back written byte");

    // Set 7: fill eight ways, revisit, dirty the oldest, then evict
    for (int t = 0; t < 8; t++) access(0, mkAddr(t + 40, 7, t), 8'h00, "R5 fill empty way");
    for (int t = 0; t < 8; t++) access(0, mkAddr(t + 40, 7, 31 - t), 8'h00, "R5 all eight resident");
    access(1, mkAddr(40, 7, 3), 8'h5C, "R3 dirty oldest line");
    access(0, mkAddr(48, 7, 0), 8'h00, "R6 R7 evict oldest dirty");
    access(0, mkAddr(49, 7, 1), 8'h00, "R6 R8 evict next clean");
    access(0, mkAddr(40, 7, 3), 8'h00, "R6 R7 refetch written-back data");
    access(0, 32'h0000_1221, 8'h00, "R11 other set untouched");

    // Mixed traffic across two sets with more tags than ways
    for (int i = 0; i < 400; i++) begin
      int  t, st;
      bit  w;
      t  = int'($urandom % 12) + 100;
      st = (($urandom % 2) == 0) ? 3 : 4;
      w  = ($urandom % 3) == 0;
      access(w, mkAddr(t, st, int'($urandom % 32)), 8'($urandom), "R6 R7 mixed traffic");
    end
    access(0, 32'h0000_1221, 8'h00, "R11 set 1 still resident");

    chk(holdErr == 0, "R10 request fields held until acknowledge", holdErr, 0);
    summary();
    $finish;
  end
endmodule